// File: doc/BRIEF.md
# Output Rounder and Saturating Limiter

This block sits at the end of a filter datapath. It takes a wide signed result and turns it into a 16-bit output word. At run time, a 3-bit select picks which output bit is the last significant one. The value is rounded to nearest at that bit, and every bit below it is forced to zero. If the rounded value does not fit in 16 bits, the word is clamped to the largest positive or largest negative code, and a limit flag is raised. A format bit chooses between two's complement and offset binary. Offset binary is the two's complement word with its top bit inverted.

The 24-bit input carries fixed-point data. A weighting bit selects where the 16-bit output window sits in the input. In unity-gain weighting the window is input bits 19..4, so the output LSB has weight 2^-15. In half-gain weighting the window is input bits 20..5, which gives a -6 dB output with an LSB weight of 2^-14. The upper input bits must be a clean sign extension of the window, or the value has overflowed. The round select, format bit and weighting bit are captured with each accepted sample. One register stage holds the word and the flag, and a valid output marks new results.

Top module: `out_round_limit`

## Requirements
- R1: A synchronous reset that is high at a clock edge clears `out_valid`, `out_word` and `limit` to zero.
- R2: `out_valid` is high for exactly the cycle after a clock edge at which `in_valid` was high. While `in_valid` is low, `out_word` and `limit` hold their values whatever the other inputs do.
- R3: With `rnd_sel` = k (0..7), the window value v is rounded as floor(v/2^k + 1/2)·2^k, in output LSB units. This is round to nearest, with exact halves going toward plus infinity.
- R4: When the result is not limited, output bits k-1..0 are zero. For `rnd_sel` = 0 no bit is cleared, and for 7 bits 6..0 are cleared.
- R5: With `twos_fmt` = 1 the word is two's complement. With `twos_fmt` = 0 it is the same word with bit 15 inverted (offset binary).
- R6: A rounded value above +32767 gives 7FFF (two's complement) or FFFF (offset binary), with `limit` = 1.
- R7: A rounded value below -32768 gives 8000 (two's complement) or 0000 (offset binary), with `limit` = 1.
- R8: Overflow is judged after the rounding increment, so a carry out of rounding alone can cause saturation.
- R9: With `half_gain` = 0 the window is `in_data[19:4]` and rounding adds at bit 3+k. With `half_gain` = 1 the window is `in_data[20:5]` and rounding adds at bit 4+k.
- R10: `limit` is 0 for every accepted sample whose rounded value fits in 16 signed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept the sample on this edge |
| in_data | input | 24 | Signed datapath result |
| rnd_sel | input | 3 | Index of the last significant output bit |
| twos_fmt | input | 1 | 1: two's complement, 0: offset binary |
| half_gain | input | 1 | 1: window shifted up one bit (-6 dB) |
| out_valid | output | 1 | New result present |
| out_word | output | 16 | Rounded, limited output word |
| limit | output | 1 | Result was saturated |

## Verification
The hardest case to reach is a value that fits before rounding but overflows only because of the rounding carry. Uniform random words almost never land in the narrow band just under the positive full-scale code with the rounding bit set. The stimulus therefore builds inputs around the window's top code on purpose. It places the value exactly at, one below, and one above the half point for each select and both weightings. It also mixes random samples drawn from narrow, edge-of-range and full-width magnitude classes.

// File: rtl/out_round_limit.sv
module out_round_limit #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int SEL_W = 3,
  parameter int LOW_U = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [SEL_W-1:0] rnd_sel,
  input  logic             twos_fmt,
  input  logic             half_gain,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word,
  output logic             limit
);
  localparam int LOW_H = LOW_U + 1;
  localparam int SUM_W = IN_W + 1;
  localparam int TOP_W = SUM_W - OUT_W + 1;
  localparam int SH_W  = $clog2(SUM_W + 1);

  initial begin
    if (LOW_U < 1 || LOW_H + OUT_W > IN_W || (1 << SEL_W) > OUT_W)
      $error("out_round_limit: parameter set leaves no room for the window");
  end

  logic [SH_W-1:0]         low_pos;
  logic [SH_W-1:0]         inc_pos;
  logic signed [SUM_W-1:0] ext;
  logic signed [SUM_W-1:0] inc;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] scaled;
  logic [TOP_W-1:0]        top;
  logic                    ovf;
  logic [OUT_W-1:0]        keep_mask;
  logic [OUT_W-1:0]        sat_code;
  logic [OUT_W-1:0]        tc_word;
  logic [OUT_W-1:0]        fmt_word;

  assign low_pos = half_gain ? SH_W'(LOW_H) : SH_W'(LOW_U);
  assign inc_pos = low_pos + SH_W'(rnd_sel) - SH_W'(1);
  assign ext     = signed'({in_data[IN_W-1], in_data});
  assign inc     = signed'(SUM_W'(1) << inc_pos);
  assign sum     = ext + inc;
  assign scaled  = sum >>> low_pos;
  assign top     = scaled[SUM_W-1:OUT_W-1];
  assign ovf     = !((&top) || (~|top));

  assign keep_mask = ~((OUT_W'(1) << rnd_sel) - OUT_W'(1));
  assign sat_code  = sum[SUM_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                  : {1'b0, {(OUT_W-1){1'b1}}};
  assign tc_word   = ovf ? sat_code : (scaled[OUT_W-1:0] & keep_mask);
  assign fmt_word  = {tc_word[OUT_W-1] ^ ~twos_fmt, tc_word[OUT_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      limit     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= fmt_word;
        limit    <= ovf;
      end
    end
  end
endmodule

module out_round_limit_chk #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic [SEL_W-1:0] rnd_sel,
  input logic             twos_fmt,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word,
  input logic             limit
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0 && !limit));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(limit)));

  a_r4_low_cleared: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (limit ||
      (out_word & ((OUT_W'(1) << $past(rnd_sel)) - OUT_W'(1))) == '0));

  a_r6_sat_code: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!limit ||
      (((out_word[OUT_W-2:0] == '1) || (out_word[OUT_W-2:0] == '0)) &&
       ((out_word[OUT_W-1] != out_word[OUT_W-2]) == $past(twos_fmt)))));

  a_r10_small_no_limit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((&in_data[IN_W-1:IN_W-6]) || (~|in_data[IN_W-1:IN_W-6])))
      |=> !limit);
endmodule

bind out_round_limit out_round_limit_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .rnd_sel(rnd_sel), .twos_fmt(twos_fmt), .out_valid(out_valid),
  .out_word(out_word), .limit(limit));

// File: tb/tb_out_round_limit.sv
module tb_out_round_limit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic [2:0]  rnd_sel = '0;
  logic        twos_fmt = 1'b1;
  logic        half_gain = 1'b0;
  logic        out_valid;
  logic [15:0] out_word;
  logic        limit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  out_round_limit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .rnd_sel(rnd_sel), .twos_fmt(twos_fmt), .half_gain(half_gain),
    .out_valid(out_valid), .out_word(out_word), .limit(limit));

  function automatic longint model_q(logic [23:0] d, int k, bit hg);
    longint x, y;
    int low;
    x = $signed(d);
    low = hg ? 5 : 4;
    y = (x + (longint'(1) <<< (low + k - 1))) >>> (low + k);
    return y <<< k;
  endfunction

  function automatic logic [16:0] model_out(logic [23:0] d, int k, bit fmt, bit hg);
    longint q;
    logic [15:0] w;
    logic lim;
    q = model_q(d, k, hg);
    lim = 1'b0;
    if (q > 32767) begin w = 16'h7FFF; lim = 1'b1; end
    else if (q < -32768) begin w = 16'h8000; lim = 1'b1; end
    else w = q[15:0];
    if (!fmt) w[15] = ~w[15];
    return {lim, w};
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic apply(logic [23:0] d, int k, bit fmt, bit hg, string tag);
    logic [16:0] e;
    longint q;
    string req;
    in_valid = 1'b1; in_data = d; rnd_sel = 3'(k); twos_fmt = fmt; half_gain = hg;
    @(negedge clk);
    in_valid = 1'b0;
    e = model_out(d, k, fmt, hg);
    q = model_q(d, k, hg);
    if (tag != "") req = tag;
    else if (q > 32767) req = "R6";
    else if (q < -32768) req = "R7";
    else if (!fmt) req = "R5";
    else if (hg) req = "R9";
    else req = "R3";
    check({req, " word"}, out_word, e[15:0]);
    check(e[16] ? req : "R10", limit, e[16]);
    check("R2 valid", out_valid, 1);
    if (!e[16]) check("R4 low bits", out_word & 16'((1 << k) - 1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] held_w;
    logic        held_l;
    void'($urandom(32'h5EED_0042));
    @(negedge clk); @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 word", out_word, 0);
    check("R1 limit", limit, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3: exact halves and neighbours, every select, both weightings
    for (int hg = 0; hg < 2; hg++)
      for (int k = 0; k < 8; k++) begin
        int b;
        b = (hg ? 5 : 4) + k - 1;
        apply(24'(1 << b), k, 1, bit'(hg), "R3");
        apply(24'((1 << b) - 1), k, 1, bit'(hg), "R3");
        apply(-24'(1 << b), k, 1, bit'(hg), "R3");
        apply(-24'((1 << b) + 1), k, 1, bit'(hg), "R3");
      end

    // R8: rounding carry pushes top code over full scale
    apply(24'h07FFF8, 0, 1, 0, "R8");
    apply(24'h07FFF8, 0, 0, 0, "R8");
    apply(24'h07FF80, 4, 1, 0, "R8");
    apply(24'h0FFFF0, 0, 1, 1, "R8");
    apply(24'h07FFF7, 0, 1, 0, "R8");
    apply(24'h07FFF0, 0, 1, 0, "R8");

    // R6 / R7: extremes of the input range in both formats
    apply(24'h7FFFFF, 0, 1, 0, "R6");
    apply(24'h7FFFFF, 3, 0, 0, "R6");
    apply(24'h800000, 0, 1, 0, "R7");
    apply(24'h800000, 7, 0, 1, "R7");
    apply(24'hF80000, 0, 1, 0, "R7");
    apply(24'hF7FFFF, 0, 0, 0, "R7");
    apply(24'h000000, 5, 0, 0, "R5");
    apply(24'hFFFFF0, 0, 0, 0, "R5");

    // R9: same pattern under both weightings
    apply(24'h0ABCD0, 0, 1, 0, "R9");
    apply(24'h0ABCD0, 0, 1, 1, "R9");

    // random mix of magnitude classes
    for (int i = 0; i < 600; i++) begin
      logic [23:0] d;
      int cls;
      cls = $urandom_range(3);
      d = 24'($urandom);
      if (cls == 0) d = 24'($signed(d[17:0]));
      else if (cls == 1) d = {{4{d[19]}}, d[19:0]};
      else if (cls == 2) d = {{3{d[20]}}, d[20:6], 6'($urandom_range(63))};
      apply(d, int'($urandom_range(7)), bit'($urandom_range(1)), bit'($urandom_range(1)), "");
    end

    // R2: inputs moving without valid leave the outputs untouched
    apply(24'h012340, 2, 1, 0, "R2");
    held_w = out_word; held_l = limit;
    in_data = 24'h7FFFFF; rnd_sel = 3'd7; twos_fmt = 1'b0; half_gain = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 hold word", out_word, held_w);
    check("R2 hold limit", limit, held_l);
    check("R2 valid low", out_valid, 0);

    // R1: reset mid-run
    apply(24'h7FFFFF, 0, 1, 0, "R6");
    rst = 1'b1;
    @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 word", out_word, 0);
    check("R1 limit", limit, 0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule